// File: doc/BRIEF.md
# Separable 3D Transform Cube Engine

This block turns a video cube of 8 rows × 8 columns × 8 consecutive frames into 512 transform coefficients. The transform is separable and uses an 8-point integer kernel whose entries are only 0, +1 and −1. It therefore needs adders and no multipliers.

Pixels enter as one row of eight per cycle, frame by frame. A horizontal kernel transforms each row as it arrives. A two-bank corner-turn store then hands the row results, column by column, to a vertical kernel. The vertical kernel writes each plane's 2D coefficients into a cube store. Once all eight planes are in the store, a third kernel reads one spatial position per cycle across the eight planes and transforms along the frame axis. It emits eight coefficients per beat, one beat per position, for 64 beats.

The input is held off with `in_ready` while a cube is being emitted. The output has no back-pressure.

Top module: `xf3_cube`

## Requirements
- R1: While reset is high and in the cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Each of the three passes applies the 8×8 kernel K, giving y[k] = Σn K[k][n]·x[n]. The rows of K, for k = 0 to 7, are:
  - (1,1,1,1,1,1,1,1)
  - (1,1,1,0,0,−1,−1,−1)
  - (1,0,0,−1,−1,0,0,1)
  - (1,0,−1,−1,1,1,0,−1)
  - (1,−1,−1,1,1,−1,−1,1)
  - (1,−1,0,1,−1,0,1,−1)
  - (0,−1,1,0,0,1,−1,0)
  - (0,−1,1,−1,1,−1,1,0)
- R3: Row beat number 8·f + r (counting from 0 within a cube) carries frame f, row r. Pixel c sits in `in_pix[8c+7:8c]` and is unsigned. The beat at position (i, j) carries the value Y[t][i][j] = Σf Σr Σc K[t][f]·K[i][r]·K[j][c]·X[f][r][c] in lane t, which is `out_coef[18t+17:18t]`, two's complement.
- R4: A cube's 64 output beats come on consecutive cycles in raster order, (0,0), (0,1), … (7,7), with `out_col` changing fastest.
- R5: `in_ready` stays high while the 64 rows of a cube are offered, so rows may arrive back to back. It goes low once the 64th row is accepted and stays low until the cube's final beat is presented.
- R6: A cycle with `in_valid` low accepts nothing, whatever is on `in_pix`.
- R7: A cube with every pixel at 255 yields +130560 in lane 0 at (0,0) and 0 in every other coefficient. No lane overflows.
- R8: Each cube produces exactly 64 beats with `out_valid` high; `out_valid` is low otherwise.
- R9: `in_ready` is high again while the final beat of a cube is presented, and the next cube is transformed independently of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel row is offered |
| in_ready | output | 1 | A row offered this cycle is taken |
| in_pix | input | 64 | Eight unsigned 8-bit pixels of one row |
| out_valid | output | 1 | A coefficient beat is presented |
| out_row | output | 3 | Vertical frequency index of the beat |
| out_col | output | 3 | Horizontal frequency index of the beat |
| out_coef | output | 144 | Eight signed 18-bit coefficients, lane t = frame-axis frequency t |

## Verification
The bound checker watches the beat sequence on every cycle:
- each burst starts at position (0,0), steps by one position per cycle, and ends only after (7,7);
- `in_ready` stays low during a burst until the last beat;
- no more than 64 rows are accepted between bursts.

Only the bench's cubes can show that the arithmetic is right. Each cube is compared in full against a three-axis integer model; the cubes are:
- an impulse;
- a full-scale flat cube;
- a ramp;
- a checkerboard;
- pseudo-random data with idle cycles carrying junk pixels.

The bench also shows that back-to-back loading never stalls.

// File: rtl/xf3_pkg.sv
package xf3_pkg;

    // Kernel size and the derived index width.
    localparam int XF_N    = 8;
    localparam int XF_LOG  = $clog2(XF_N);
    // Bits gained per pass: the largest row of absolute entries sums to 8.
    localparam int XF_GROW = 3;
    localparam int XF_CUBE_ROWS = XF_N * XF_N;

    // Integer kernel, entries in {-1, 0, +1}.
    localparam int XF_MAT [XF_N][XF_N] = '{
        '{ 1,  1,  1,  1,  1,  1,  1,  1},
        '{ 1,  1,  1,  0,  0, -1, -1, -1},
        '{ 1,  0,  0, -1, -1,  0,  0,  1},
        '{ 1,  0, -1, -1,  1,  1,  0, -1},
        '{ 1, -1, -1,  1,  1, -1, -1,  1},
        '{ 1, -1,  0,  1, -1,  0,  1, -1},
        '{ 0, -1,  1,  0,  0,  1, -1,  0},
        '{ 0, -1,  1, -1,  1, -1,  1,  0}
    };

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } xf_phase_e;

    typedef struct packed {
        logic [XF_LOG-1:0] row;
        logic [XF_LOG-1:0] col;
    } xf_pos_t;

    function automatic logic [XF_LOG-1:0] xf_last_idx();
        return XF_LOG'(XF_N - 1);
    endfunction

endpackage

// File: rtl/xf3_unit.sv
module xf3_unit
    import xf3_pkg::*;
#(
    parameter  int IN_W  = 9,
    localparam int OUT_W = IN_W + XF_GROW
) (
    input  logic [XF_N*IN_W-1:0]  x_vec,
    output logic [XF_N*OUT_W-1:0] y_vec
);

    logic signed [IN_W-1:0]  xs  [XF_N];
    logic signed [OUT_W-1:0] acc [XF_N];

    for (genvar n = 0; n < XF_N; n++) begin : g_in
        assign xs[n] = x_vec[n*IN_W +: IN_W];
    end

    // Each output lane is an add/subtract tree picked by the kernel row.
    for (genvar k = 0; k < XF_N; k++) begin : g_lane
        always_comb begin
            acc[k] = '0;
            for (int n = 0; n < XF_N; n++) begin
                if (XF_MAT[k][n] > 0)
                    acc[k] = acc[k] + OUT_W'(xs[n]);
                else if (XF_MAT[k][n] < 0)
                    acc[k] = acc[k] - OUT_W'(xs[n]);
            end
        end
        assign y_vec[k*OUT_W +: OUT_W] = acc[k];
    end

endmodule

// File: rtl/xf3_turn.sv
module xf3_turn
    import xf3_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [XF_N*W-1:0]     wr_row_data,
    output logic                  wr_ready,
    output logic                  rd_valid,
    output logic [XF_LOG-1:0]     rd_col,
    output logic [XF_N*W-1:0]     rd_vec
);

    localparam logic [XF_LOG-1:0] LAST = XF_LOG'(XF_N - 1);

    logic [W-1:0]      bank [2][XF_N][XF_N];
    logic [1:0]        full;
    logic              wb;
    logic              rb;
    logic [XF_LOG-1:0] wr_row;
    logic              do_wr;

    assign wr_ready = !full[wb];
    assign rd_valid = full[rb];
    assign do_wr    = wr_en && wr_ready;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            for (int c = 0; c < XF_N; c++)
                bank[wb][wr_row][c] <= wr_row_data[c*W +: W];
        end
    end

    // Writer fills one bank row-wise while the reader drains the other column-wise.
    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= '0;
            wb     <= 1'b0;
            rb     <= 1'b0;
            wr_row <= '0;
            rd_col <= '0;
        end else begin
            if (do_wr) begin
                wr_row <= wr_row + 1'b1;
                if (wr_row == LAST) begin
                    full[wb] <= 1'b1;
                    wb       <= ~wb;
                end
            end
            if (rd_valid) begin
                rd_col <= rd_col + 1'b1;
                if (rd_col == LAST) begin
                    full[rb] <= 1'b0;
                    rb       <= ~rb;
                end
            end
        end
    end

    for (genvar n = 0; n < XF_N; n++) begin : g_rd
        assign rd_vec[n*W +: W] = bank[rb][n][rd_col];
    end

endmodule

// File: rtl/xf3_store.sv
module xf3_store
    import xf3_pkg::*;
#(
    parameter int W = 15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  col_valid,
    input  logic [XF_LOG-1:0]     col_idx,
    input  logic [XF_N*W-1:0]     col_vec,
    output logic                  draining,
    output logic                  drain_last,
    output xf_pos_t               pos,
    output logic [XF_N*W-1:0]     plane_vec
);

    localparam logic [XF_LOG-1:0] LAST = XF_LOG'(XF_N - 1);

    // cmem[plane][vertical freq][horizontal freq]
    logic [W-1:0]          cmem [XF_N][XF_N][XF_N];
    xf_phase_e             phase;
    logic [XF_LOG-1:0]     plane;
    logic [2*XF_LOG-1:0]   pos_flat;

    assign draining   = (phase == PH_DRAIN);
    assign pos_flat   = pos;
    assign drain_last = draining && (pos_flat == '1);

    always_ff @(posedge clk) begin
        if (col_valid) begin
            for (int i = 0; i < XF_N; i++)
                cmem[plane][i][col_idx] <= col_vec[i*W +: W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FILL;
            plane <= '0;
            pos   <= '0;
        end else begin
            unique case (phase)
                PH_FILL: begin
                    if (col_valid && col_idx == LAST) begin
                        plane <= plane + 1'b1;
                        if (plane == LAST)
                            phase <= PH_DRAIN;
                    end
                end
                PH_DRAIN: begin
                    pos <= pos_flat + 1'b1;
                    if (pos_flat == '1)
                        phase <= PH_FILL;
                end
                default: phase <= PH_FILL;
            endcase
        end
    end

    // All eight planes at one spatial position feed the frame-axis kernel.
    for (genvar f = 0; f < XF_N; f++) begin : g_plane
        assign plane_vec[f*W +: W] = cmem[f][pos.row][pos.col];
    end

endmodule

// File: rtl/xf3_cube.sv
module xf3_cube
    import xf3_pkg::*;
#(
    parameter  int PIX_W = 8,
    localparam int W3    = PIX_W + 1 + 3 * XF_GROW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [XF_N*PIX_W-1:0]  in_pix,
    output logic                   out_valid,
    output logic [XF_LOG-1:0]      out_row,
    output logic [XF_LOG-1:0]      out_col,
    output logic [XF_N*W3-1:0]     out_coef
);

    localparam int W0 = PIX_W + 1;
    localparam int W1 = W0 + XF_GROW;
    localparam int W2 = W1 + XF_GROW;
    localparam int CNT_W = $clog2(XF_CUBE_ROWS + 1);
    localparam logic [CNT_W-1:0] CUBE_ROWS = CNT_W'(XF_CUBE_ROWS);

    logic [XF_N*W0-1:0] row_in;
    logic [XF_N*W1-1:0] row_out;
    logic [XF_N*W1-1:0] tp_vec;
    logic [XF_N*W2-1:0] col_out;
    logic [XF_N*W2-1:0] st_vec;
    logic [XF_N*W3-1:0] tmp_out;
    logic               tp_wr_ready;
    logic               tp_valid;
    logic [XF_LOG-1:0]  tp_col;
    logic               st_draining;
    logic               st_last;
    xf_pos_t            st_pos;
    logic [CNT_W-1:0]   in_cnt;
    logic               accept;

    // Pixels are unsigned: widen with a zero sign bit.
    for (genvar n = 0; n < XF_N; n++) begin : g_pix
        assign row_in[n*W0 +: W0] = {1'b0, in_pix[n*PIX_W +: PIX_W]};
    end

    assign in_ready = !st_draining && (in_cnt != CUBE_ROWS) && tp_wr_ready;
    assign accept   = in_valid && in_ready;

    xf3_unit #(.IN_W(W0)) u_row (
        .x_vec (row_in),
        .y_vec (row_out)
    );

    xf3_turn #(.W(W1)) u_turn (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (accept),
        .wr_row_data (row_out),
        .wr_ready    (tp_wr_ready),
        .rd_valid    (tp_valid),
        .rd_col      (tp_col),
        .rd_vec      (tp_vec)
    );

    xf3_unit #(.IN_W(W1)) u_col (
        .x_vec (tp_vec),
        .y_vec (col_out)
    );

    xf3_store #(.W(W2)) u_store (
        .clk        (clk),
        .rst        (rst),
        .col_valid  (tp_valid),
        .col_idx    (tp_col),
        .col_vec    (col_out),
        .draining   (st_draining),
        .drain_last (st_last),
        .pos        (st_pos),
        .plane_vec  (st_vec)
    );

    xf3_unit #(.IN_W(W2)) u_time (
        .x_vec (st_vec),
        .y_vec (tmp_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            in_cnt <= '0;
        else if (st_last)
            in_cnt <= '0;
        else if (accept)
            in_cnt <= in_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_row   <= '0;
            out_col   <= '0;
            out_coef  <= '0;
        end else begin
            out_valid <= st_draining;
            out_row   <= st_pos.row;
            out_col   <= st_pos.col;
            out_coef  <= tmp_out;
        end
    end

endmodule

// File: rtl/xf3_cube_chk.sv
module xf3_cube_chk
    import xf3_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [XF_LOG-1:0] out_row,
    input logic [XF_LOG-1:0] out_col
);

    logic [2*XF_LOG-1:0] pos;
    logic [7:0]          acc_cnt;
    logic                last_beat;

    assign pos       = {out_row, out_col};
    assign last_beat = out_valid && (pos == '1);

    always_ff @(posedge clk) begin
        if (rst)
            acc_cnt <= '0;
        else if (last_beat)
            acc_cnt <= '0;
        else if (in_valid && in_ready)
            acc_cnt <= acc_cnt + 1'b1;
    end

    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    // R4
    a_r4_burst_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (pos == '0));

    // R4
    a_r4_raster_step: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (pos == $past(pos) + 1'b1));

    // R8
    a_r8_burst_complete: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> ($past(pos) == '1));

    // R5
    a_r5_closed_in_burst: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos != '1) |-> !in_ready);

    // R5
    a_r5_cube_cap: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> (acc_cnt < 8'(XF_CUBE_ROWS)));

endmodule

bind xf3_cube xf3_cube_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_row   (out_row),
    .out_col   (out_col)
);

// File: tb/sim_xf3_cube.sv
module sim_xf3_cube;

    localparam int PW = 8;
    localparam int CW = 18;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic             in_ready;
    logic [8*PW-1:0]  in_pix;
    logic             out_valid;
    logic [2:0]       out_row;
    logic [2:0]       out_col;
    logic [8*CW-1:0]  out_coef;

    always #2.5 clk = ~clk;

    xf3_cube #(.PIX_W(PW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_row   (out_row),
        .out_col   (out_col),
        .out_coef  (out_coef)
    );

    // Kernel from R2, kept in the bench independently of the RTL.
    int km [8][8] = '{
        '{ 1,  1,  1,  1,  1,  1,  1,  1},
        '{ 1,  1,  1,  0,  0, -1, -1, -1},
        '{ 1,  0,  0, -1, -1,  0,  0,  1},
        '{ 1,  0, -1, -1,  1,  1,  0, -1},
        '{ 1, -1, -1,  1,  1, -1, -1,  1},
        '{ 1, -1,  0,  1, -1,  0,  1, -1},
        '{ 0, -1,  1,  0,  0,  1, -1,  0},
        '{ 0, -1,  1, -1,  1, -1,  1,  0}
    };

    int checks = 0;
    int errors = 0;
    int px    [8][8][8];
    int ref_y [8][8][8];
    int got   [8][8][8];
    int beats;
    int order_bad;
    int seed = 32'h1234_5678;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Collector: outputs are registered, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if ({out_row, out_col} != beats[5:0]) order_bad++;
            for (int t = 0; t < 8; t++)
                got[t][out_row][out_col] = $signed(out_coef[t*CW +: CW]);
            beats++;
        end
    end

    task automatic fill(input int kind);
        for (int f = 0; f < 8; f++)
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++) begin
                    case (kind)
                        0: px[f][r][c] = 255;
                        1: px[f][r][c] = (f == 3 && r == 5 && c == 2) ? 200 : 0;
                        2: px[f][r][c] = (f*29 + r*11 + c*7) % 256;
                        3: begin
                            seed = seed * 1103515245 + 12345;
                            px[f][r][c] = (seed >>> 16) & 255;
                        end
                        default: px[f][r][c] = ((f + r + c) % 2 == 1) ? 255 : 0;
                    endcase
                end
    endtask

    task automatic model();
        int a1 [8][8][8];
        int a2 [8][8][8];
        for (int f = 0; f < 8; f++)
            for (int r = 0; r < 8; r++)
                for (int j = 0; j < 8; j++) begin
                    a1[f][r][j] = 0;
                    for (int c = 0; c < 8; c++)
                        a1[f][r][j] += km[j][c] * px[f][r][c];
                end
        for (int f = 0; f < 8; f++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                    a2[f][i][j] = 0;
                    for (int r = 0; r < 8; r++)
                        a2[f][i][j] += km[i][r] * a1[f][r][j];
                end
        for (int t = 0; t < 8; t++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                    ref_y[t][i][j] = 0;
                    for (int f = 0; f < 8; f++)
                        ref_y[t][i][j] += km[t][f] * a2[f][i][j];
                end
    endtask

    task automatic run_cube(input int kind, input bit gaps, input string tag);
        int stalls;
        int busy_bad;
        int guard;
        fill(kind);
        model();
        beats = 0;
        order_bad = 0;
        stalls = 0;
        for (int idx = 0; idx < 64; idx++) begin
            if (gaps && (idx % 5 == 2)) begin
                // R6: junk pixels with in_valid low must not be taken.
                in_valid = 1'b0;
                in_pix   = '1;
                @(negedge clk);
            end
            in_valid = 1'b1;
            for (int c = 0; c < 8; c++)
                in_pix[c*PW +: PW] = PW'(px[idx/8][idx%8][c]);
            while (!in_ready) begin
                stalls++;
                @(negedge clk);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(stalls == 0, "R5", "stall cycles while loading", stalls, 0);

        busy_bad = 0;
        guard = 0;
        while (guard < 300) begin
            @(negedge clk);
            guard++;
            if (out_valid && out_row == 3'd7 && out_col == 3'd7) break;
            if (in_ready) busy_bad++;
        end
        check(busy_bad == 0, "R5", "in_ready high while cube busy", busy_bad, 0);
        check(in_ready == 1'b1, "R9", "in_ready with final beat", int'(in_ready), 1);
        @(negedge clk);
        check(beats == 64, "R8", "beats per cube", beats, 64);
        check(out_valid == 1'b0, "R8", "out_valid after burst", int'(out_valid), 0);
        check(order_bad == 0, "R4", "raster order violations", order_bad, 0);
        for (int t = 0; t < 8; t++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    check(got[t][i][j] == ref_y[t][i][j], tag, "coefficient",
                          got[t][i][j], ref_y[t][i][j]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_pix   = '0;
        beats    = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R2: a single nonzero pixel exposes kernel column products.
        run_cube(1, 1'b0, "R2");
        // R7: full-scale flat cube.
        run_cube(0, 1'b0, "R7");
        check(got[0][0][0] == 130560, "R7", "DC of flat 255 cube", got[0][0][0], 130560);
        // R3: ramp and checkerboard.
        run_cube(2, 1'b0, "R3");
        run_cube(4, 1'b0, "R3");
        // R6: pseudo-random data with idle junk cycles.
        run_cube(3, 1'b1, "R6");
        // R9: another cube right after, independent of the last.
        run_cube(3, 1'b0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule